// File: doc/BRIEF.md
# Ten-Instruction Accumulator Core

This block is a small accumulator machine with two data registers, the accumulator A and a general register R, plus a registered output port. It reads one 4-bit instruction code per clock cycle from `op_code`, but only in cycles where `op_valid` is high. Data operands come from the `data_in` port. Results can go only to A, to R or to the output register.

The ten instructions cover several kinds of work. Two load A from the input. One copies A into R, and one loads R from the input. Two drive A or R onto the output. Four are arithmetic or logic operations on A: sum, bitwise OR and bitwise AND (each with R), and complement.

A host uses the core by streaming codes. For example, the sequence 5, 1, 7, 4 places one input word in R and another in A, adds them, and then shows the sum on `out_data`.

The core has no state machine. The decode stage maps each code to a control word through one `unique case`. This covers the named codes `OP_NOP`, `OP_LDA_IMM`, `OP_CPY_AR`, `OP_OUT_R`, `OP_OUT_A`, `OP_LDR_IN`, `OP_LDA_IN`, `OP_ADD`, `OP_OR`, `OP_AND` and `OP_NOT`, plus an idle control word for every other code.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, A, R and the output register all become zero. After reset, `out_data` reads 0.
- R2: Codes 1 and 6 load `data_in` into A.
- R3: Code 2 copies A into R, and code 5 loads `data_in` into R. Every other code leaves R unchanged.
- R4: Code 4 drives A onto `out_data`, and code 3 drives R onto `out_data`. Under any other code, `out_data` keeps its last value.
- R5: Code 7 writes A+R into A, with the sum taken modulo 2^W (the carry out is dropped).
- R6: Code 8 writes A OR R into A, and code 9 writes A AND R into A.
- R7: Code 10 writes the bitwise complement of A into A.
- R8: Codes 2, 3, 4 and 5 leave A unchanged.
- R9: Codes 0 and 11 to 15 change neither A, R nor the output register.
- R10: In a cycle where `op_valid` is low, no state changes, whatever the code and data.
- R11: The code sequence 5, 1, 7, 4, with inputs x then y on the first two steps, leaves x+y on `out_data` after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | The instruction code in this cycle is to be executed |
| op_code | input | 4 | Binary instruction code, 0 to 15 |
| data_in | input | W | Input data port |
| out_data | output | W | Registered output port |

## Verification
The test program builds operand pairs in R and A, runs each operation, and reads the result back through code 4 or code 3. This makes every register and every operation visible at the single output.

The operands were chosen to separate operations from one another. The pair 0x3C and 0x51 gives different results for sum, OR and AND. The pair 0xFF plus 0x02 exercises the dropped carry.

Reading R after loads of A, and reading A after loads of R, shows any write that reached the wrong destination. Inputs changed during no-operation codes and during invalid cycles show whether those cycles leak into the state.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_LDA_IMM = 4'd1,
        OP_CPY_AR  = 4'd2,
        OP_OUT_R   = 4'd3,
        OP_OUT_A   = 4'd4,
        OP_LDR_IN  = 4'd5,
        OP_LDA_IN  = 4'd6,
        OP_ADD     = 4'd7,
        OP_OR      = 4'd8,
        OP_AND     = 4'd9,
        OP_NOT     = 4'd10
    } opcode_e;

    typedef enum logic [2:0] {
        ASEL_IN,
        ASEL_ADD,
        ASEL_OR,
        ASEL_AND,
        ASEL_NOT
    } asel_e;

    typedef struct packed {
        logic  a_we;
        asel_e a_sel;
        logic  r_we;
        logic  r_from_in;
        logic  out_we;
        logic  out_from_r;
    } ctrl_t;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
    import acc_core_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl = '{a_we: 1'b0, a_sel: ASEL_IN, r_we: 1'b0,
                 r_from_in: 1'b0, out_we: 1'b0, out_from_r: 1'b0};
        unique case (op_code)
            OP_LDA_IMM,
            OP_LDA_IN: begin
                ctrl.a_we  = 1'b1;
                ctrl.a_sel = ASEL_IN;
            end
            OP_CPY_AR: ctrl.r_we = 1'b1;
            OP_LDR_IN: begin
                ctrl.r_we      = 1'b1;
                ctrl.r_from_in = 1'b1;
            end
            OP_OUT_R: begin
                ctrl.out_we     = 1'b1;
                ctrl.out_from_r = 1'b1;
            end
            OP_OUT_A: ctrl.out_we = 1'b1;
            OP_ADD: begin
                ctrl.a_we  = 1'b1;
                ctrl.a_sel = ASEL_ADD;
            end
            OP_OR: begin
                ctrl.a_we  = 1'b1;
                ctrl.a_sel = ASEL_OR;
            end
            OP_AND: begin
                ctrl.a_we  = 1'b1;
                ctrl.a_sel = ASEL_AND;
            end
            OP_NOT: begin
                ctrl.a_we  = 1'b1;
                ctrl.a_sel = ASEL_NOT;
            end
            default: ;  // OP_NOP and unused codes: idle control word (R9)
        endcase
    end

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int W = 8
) (
    input  asel_e          sel,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   r,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   y
);

    always_comb begin
        unique case (sel)
            ASEL_IN:  y = din;
            ASEL_ADD: y = a + r;   // carry dropped, modulo 2^W
            ASEL_OR:  y = a | r;
            ASEL_AND: y = a & r;
            ASEL_NOT: y = ~a;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    data_in,
    output logic [W-1:0]    out_data
);

    ctrl_t        ctrl;
    logic [W-1:0] a_q, r_q, out_q, alu_y;

    acc_core_decode u_decode (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    acc_core_alu #(.W(W)) u_alu (
        .sel (ctrl.a_sel),
        .a   (a_q),
        .r   (r_q),
        .din (data_in),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            r_q   <= '0;
            out_q <= '0;
        end else if (op_valid) begin
            if (ctrl.a_we)   a_q   <= alu_y;
            if (ctrl.r_we)   r_q   <= ctrl.r_from_in ? data_in : a_q;
            if (ctrl.out_we) out_q <= ctrl.out_from_r ? r_q : a_q;
        end
    end

    assign out_data = out_q;

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(a_q) && $stable(r_q) && $stable(out_q)));

    p_add_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ADD) |=> a_q == W'($past(a_q) + $past(r_q)));

    p_out_a_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_OUT_A) |=> out_q == $past(a_q));

    p_out_r_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_OUT_R) |=> out_q == $past(r_q));

    p_out_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code != OP_OUT_A && op_code != OP_OUT_R) |=> $stable(out_q));

    p_r_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (op_code != OP_CPY_AR && op_code != OP_LDR_IN) |=> $stable(r_q));

    p_a_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code inside {OP_CPY_AR, OP_OUT_R, OP_OUT_A, OP_LDR_IN}))
        |=> $stable(a_q));

    p_nop_r9: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_NOP || op_code > OP_NOT)
        |=> ($stable(a_q) && $stable(r_q) && $stable(out_q)));

endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;

    localparam int  W        = 8;
    localparam time CLK_PER  = 10;
    localparam int  NVEC     = 43;
    // vector: {valid, code[3:0], din[7:0], chk, exp[7:0], req[3:0]}
    localparam int  VW       = 26;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    acc_core #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .data_in  (data_in),
        .out_data (out_data)
    );

    function automatic logic [VW-1:0] v(input logic val, input logic [3:0] c,
                                         input logic [7:0] d, input logic k,
                                         input logic [7:0] e, input logic [3:0] q);
        return {val, c, d, k, e, q};
    endfunction

    localparam logic [VW-1:0] VEC [NVEC] = '{
        v(1, 4,  8'h00, 1, 8'h00, 1),  // R1: A zero after reset
        v(1, 3,  8'h00, 1, 8'h00, 1),  // R1: R zero after reset
        v(1, 5,  8'h3C, 0, 8'h00, 0),  // R11 step 1: R = 3C
        v(1, 1,  8'h51, 0, 8'h00, 0),  // R11 step 2: A = 51
        v(1, 7,  8'h00, 0, 8'h00, 0),  // R11 step 3: A = 8D
        v(1, 4,  8'h00, 1, 8'h8D, 11), // R11: sum on OUT
        v(1, 3,  8'h00, 1, 8'h3C, 4),  // R4: R on OUT
        v(1, 8,  8'h00, 0, 8'h00, 0),  // A = BD
        v(1, 4,  8'h00, 1, 8'hBD, 6),  // R6: OR
        v(1, 9,  8'h00, 0, 8'h00, 0),  // A = 3C
        v(1, 4,  8'h00, 1, 8'h3C, 6),  // R6: AND
        v(1, 10, 8'h00, 0, 8'h00, 0),  // A = C3
        v(1, 4,  8'h00, 1, 8'hC3, 7),  // R7: complement
        v(1, 6,  8'hF0, 0, 8'h00, 0),  // A = F0 via code 6
        v(1, 4,  8'h00, 1, 8'hF0, 2),  // R2: load from input
        v(1, 2,  8'h11, 0, 8'h00, 0),  // R = A = F0
        v(1, 3,  8'h00, 1, 8'hF0, 3),  // R3: copy A into R
        v(1, 1,  8'h0F, 0, 8'h00, 0),  // A = 0F
        v(1, 3,  8'h00, 1, 8'hF0, 3),  // R3: R untouched by code 1
        v(1, 5,  8'hAA, 0, 8'h00, 0),  // R = AA
        v(1, 4,  8'h00, 1, 8'h0F, 8),  // R8: A untouched by codes 5 and 3
        v(1, 7,  8'h00, 0, 8'h00, 0),  // A = B9
        v(1, 4,  8'h00, 1, 8'hB9, 5),  // R5: plain sum
        v(1, 1,  8'hFF, 0, 8'h00, 0),
        v(1, 5,  8'h02, 0, 8'h00, 0),
        v(1, 7,  8'h00, 0, 8'h00, 0),  // A = 01 with carry dropped
        v(1, 4,  8'h00, 1, 8'h01, 5),  // R5: wrap
        v(1, 0,  8'h77, 0, 8'h00, 0),
        v(1, 11, 8'h77, 0, 8'h00, 0),
        v(1, 13, 8'h77, 0, 8'h00, 0),
        v(1, 15, 8'h77, 1, 8'h01, 9),  // R9: OUT unchanged by no-ops
        v(1, 3,  8'h77, 1, 8'h02, 9),  // R9: R unchanged by no-ops
        v(1, 4,  8'h77, 1, 8'h01, 9),  // R9: A unchanged by no-ops
        v(1, 7,  8'h00, 1, 8'h01, 4),  // R4: OUT holds under code 7 (A = 03)
        v(0, 1,  8'h55, 0, 8'h00, 0),
        v(0, 5,  8'h55, 0, 8'h00, 0),
        v(0, 3,  8'h55, 1, 8'h01, 10), // R10: OUT held while invalid
        v(1, 4,  8'h00, 1, 8'h03, 10), // R10: A held while invalid
        v(1, 3,  8'h00, 1, 8'h02, 10), // R10: R held while invalid
        v(1, 1,  8'h80, 0, 8'h00, 0),
        v(1, 2,  8'h00, 0, 8'h00, 0),
        v(1, 7,  8'h00, 0, 8'h00, 0),  // 80+80 wraps to 00
        v(1, 4,  8'h00, 1, 8'h00, 5)   // R5: full carry out dropped
    };

    task automatic check(input logic [W-1:0] exp, input int req, input string what);
        checks++;
        if (out_data !== exp) begin
            errors++;
            $display("FAIL R%0d %s: out_data=%h expected=%h", req, what, out_data, exp);
        end
    endtask

    task automatic step(input logic val, input logic [3:0] c, input logic [W-1:0] d);
        @(negedge clk);
        op_valid = val;
        op_code  = c;
        data_in  = d;
        @(posedge clk);
        #(CLK_PER/4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PER/4);
        check('0, 1, "output after reset");  // R1
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][25], VEC[i][24:21], VEC[i][20:13]);
            if (VEC[i][12]) check(VEC[i][11:4], int'(VEC[i][3:0]), "vector");
        end

        // R1: reset in mid-run clears all state
        step(1, 1, 8'h5A);
        step(1, 2, 8'h00);
        step(1, 4, 8'h00);
        check(8'h5A, 4, "output before reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #(CLK_PER/4);
        check('0, 1, "output cleared by reset");
        @(negedge clk);
        rst = 1'b0;
        step(1, 4, 8'h00);
        check('0, 1, "A cleared by reset");
        step(1, 3, 8'h00);
        check('0, 1, "R cleared by reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PER * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule